// File: doc/BRIEF.md
# Serial-Updated Text Message Buffer

This block holds a short text message that a display process reads continuously, and lets a host rewrite that message at run time over an asynchronous serial line. An 8N1 receiver, clocked from the system clock, recovers each character. A small controller then stores the character in a 32-entry character store at a write pointer. No rebuild is needed to change the text, and the display side keeps reading throughout.

Two received codes act as in-band commands rather than text. Carriage return (0x0D) moves the write pointer back to location 0 and leaves the stored text as it is, so the next characters overwrite the message from the start. Escape (0x1B) blanks the whole store to spaces and moves the pointer back to 0. The display side has its own address input and gets the character at that address combinationally. That read path does not depend on the write side.

Top module: `msg_serial_text`

## Requirements
- R1: After reset (rst_ni low, asynchronous), every location reads 0x20 (space) and rx_err_o is low.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts CLK_HZ/BAUD clock cycles. A received character other than 0x0D and 0x1B is stored at the write pointer, and the pointer then advances by one.
- R3: A received 0x0D moves the write pointer to location 0 and changes no stored character. The next character is stored at location 0.
- R4: A received 0x1B sets every location to 0x20 within DEPTH cycles and moves the write pointer to 0. The next character is stored at location 0.
- R5: When the write pointer is at the last location (31), it stays there. Each further character overwrites location 31.
- R6: If the stop bit is sampled low, rx_err_o is high for exactly one cycle and nothing is stored. A good frame leaves rx_err_o low.
- R7: A low pulse on rx_i that is shorter than half a bit period is ignored. Nothing is stored and no error is flagged.
- R8: rd_data_o is the stored character at rd_addr_i. It follows a change of rd_addr_i without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idles high |
| rx_err_o | output | 1 | One-cycle pulse on a frame with a bad stop bit |
| rd_addr_i | input | 5 | Display read address |
| rd_data_o | output | 8 | Character stored at rd_addr_i |

## Verification
The store takes a character in the cycle after the stop-bit centre sample, which lies 2 synchronizer cycles plus 9.5 bit periods after the falling edge of the start bit. An escape then needs DEPTH more cycles to finish the clear. For this reason the bench reads the store only after each frame has been followed by four idle bit periods, which is well past both deadlines. It compares all 32 locations against a behavioural model in one half clock period, which also shows that the read path is combinational. Error pulses are counted one cycle at a time over each frame window, so a pulse that lasts longer than one cycle, or a missing pulse, is caught.

// File: rtl/msg_text_pkg.sv
`timescale 1ns/1ps
package msg_text_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam logic [CHAR_W-1:0] CH_CR    = 8'h0D;
  localparam logic [CHAR_W-1:0] CH_ESC   = 8'h1B;
  localparam logic [CHAR_W-1:0] CH_SPACE = 8'h20;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/msg_uart_rx.sv
`timescale 1ns/1ps
module msg_uart_rx
  import msg_text_pkg::*;
#(
  parameter int unsigned CLK_HZ = 12_000_000,
  parameter int unsigned BAUD   = 9600
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rx_i,
  output logic              valid_o,
  output logic              err_o,
  output logic [CHAR_W-1:0] data_o
);
  localparam int unsigned BIT_CYC = CLK_HZ / BAUD;
  localparam int unsigned HALF    = BIT_CYC / 2;
  localparam int unsigned CW      = $clog2(BIT_CYC);

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        bit_q;
  logic [CHAR_W-1:0] shr_q;
  logic              rx_s;

  assign rx_s   = sync_q[1];
  assign data_o = shr_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shr_q   <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rx_i};
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (!rx_s) begin
            state_q <= RX_START;
            cnt_q   <= CW'(HALF - 1);
          end
        end
        RX_START: begin
          if (cnt_q == '0) begin
            // confirm start at its centre, else treat as glitch
            if (!rx_s) begin
              state_q <= RX_DATA;
              cnt_q   <= CW'(BIT_CYC - 1);
              bit_q   <= '0;
            end else begin
              state_q <= RX_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == '0) begin
            shr_q <= {rx_s, shr_q[CHAR_W-1:1]};
            cnt_q <= CW'(BIT_CYC - 1);
            if (bit_q == 3'd7) state_q <= RX_STOP;
            else               bit_q   <= bit_q + 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == '0) begin
            if (rx_s) valid_o <= 1'b1;
            else      err_o   <= 1'b1;
            state_q <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assert_err_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> !err_o);
  assert_err_no_valid_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |-> !valid_o);
  assert_valid_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_o |=> !valid_o);
endmodule

// File: rtl/msg_text_ctrl.sv
`timescale 1ns/1ps
module msg_text_ctrl
  import msg_text_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     valid_i,
  input  logic [CHAR_W-1:0]        char_i,
  output logic                     we_o,
  output logic [$clog2(DEPTH)-1:0] waddr_o,
  output logic [CHAR_W-1:0]        wdata_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] clr_idx_q;
  logic          clr_busy_q;
  logic          is_cmd;

  assign is_cmd = (char_i == CH_CR) || (char_i == CH_ESC);

  always_comb begin
    we_o    = 1'b0;
    waddr_o = ptr_q;
    wdata_o = char_i;
    if (clr_busy_q) begin
      we_o    = 1'b1;
      waddr_o = clr_idx_q;
      wdata_o = CH_SPACE;
    end else if (valid_i && !is_cmd) begin
      we_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      ptr_q      <= '0;
      clr_idx_q  <= '0;
      clr_busy_q <= 1'b0;
    end else if (clr_busy_q) begin
      clr_idx_q <= clr_idx_q + 1'b1;
      if (clr_idx_q == LAST) clr_busy_q <= 1'b0;
    end else if (valid_i) begin
      if (char_i == CH_CR) begin
        ptr_q <= '0;
      end else if (char_i == CH_ESC) begin
        ptr_q      <= '0;
        clr_idx_q  <= '0;
        clr_busy_q <= 1'b1;
      end else if (ptr_q != LAST) begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assert_cr_rewind_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && !clr_busy_q && char_i == CH_CR) |=> (ptr_q == '0 && !clr_busy_q));
  assert_esc_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && !clr_busy_q && char_i == CH_ESC) |=> (ptr_q == '0 && clr_busy_q && clr_idx_q == '0));
  assert_clear_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_busy_q |-> !valid_i);
  assert_ptr_sat_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && !clr_busy_q && !is_cmd && ptr_q == LAST) |=> ptr_q == LAST);
  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && !clr_busy_q && !is_cmd && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/msg_char_ram.sv
`timescale 1ns/1ps
module msg_char_ram
  import msg_text_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [CHAR_W-1:0]        wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [CHAR_W-1:0]        rdata_o
);
  logic [CHAR_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CH_SPACE;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_wr_lands_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && raddr_i == waddr_i) ##1 (raddr_i == $past(raddr_i)) |-> rdata_o == $past(wdata_i));
endmodule

// File: rtl/msg_serial_text.sv
`timescale 1ns/1ps
module msg_serial_text
  import msg_text_pkg::*;
#(
  parameter int unsigned CLK_HZ = 12_000_000,
  parameter int unsigned BAUD   = 9600,
  parameter int unsigned DEPTH  = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     rx_i,
  output logic                     rx_err_o,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [CHAR_W-1:0]        rd_data_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic              rst;
  logic              rx_valid;
  logic [CHAR_W-1:0] rx_char;
  logic              we;
  logic [AW-1:0]     waddr;
  logic [CHAR_W-1:0] wdata;

  assign rst = ~rst_ni;

  msg_uart_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_rx (
    .clk_i  (clk_i),
    .rst_i  (rst),
    .rx_i   (rx_i),
    .valid_o(rx_valid),
    .err_o  (rx_err_o),
    .data_o (rx_char)
  );

  msg_text_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_i  (rst),
    .valid_i(rx_valid),
    .char_i (rx_char),
    .we_o   (we),
    .waddr_o(waddr),
    .wdata_o(wdata)
  );

  msg_char_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i  (clk_i),
    .rst_i  (rst),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: tb/tb_msg_serial_text.sv
`timescale 1ns/1ps
module tb_msg_serial_text;
  localparam int CLK_HZ = 160_000;
  localparam int BAUD   = 10_000;
  localparam int BITC   = CLK_HZ / BAUD;
  localparam int DEPTH  = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       rx_err;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errs = 0;
  int err_hi = 0;
  logic [7:0] mdl [DEPTH];
  int mptr = 0;

  always #5 clk = ~clk;

  msg_serial_text #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rx_err_o(rx_err),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  always @(negedge clk) if (rx_err === 1'b1) err_hi++;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic sweep(input string tag);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr = i[4:0];
      #0.1;
      check(rd_data, mdl[i], tag);
    end
  endtask

  task automatic model(input logic [7:0] b);
    if (b == 8'h0D) mptr = 0;
    else if (b == 8'h1B) begin
      for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h20;
      mptr = 0;
    end else begin
      mdl[mptr] = b;
      if (mptr < DEPTH - 1) mptr++;
    end
  endtask

  task automatic send(input logic [7:0] b, input bit stop_ok, input string tag);
    int e0;
    e0 = err_hi;
    @(negedge clk);
    rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BITC) @(negedge clk);
    end
    rx = stop_ok;
    repeat (BITC) @(negedge clk);
    rx = 1'b1;
    repeat (4 * BITC) @(negedge clk);
    check(8'(err_hi - e0), stop_ok ? 8'd0 : 8'd1, tag);
    if (stop_ok) model(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h20;
    repeat (3) @(negedge clk);
    #0.1;
    check({7'd0, rx_err}, 8'd0, "R1 err low in reset");
    rst_n = 1'b1;
    sweep("R1 reset contents");

    // R2: plain characters and bit patterns
    send(8'h48, 1'b1, "R2 no error");
    send(8'h49, 1'b1, "R2 no error");
    sweep("R2 text");
    send(8'h55, 1'b1, "R2 no error");
    send(8'hAA, 1'b1, "R2 no error");
    send(8'h00, 1'b1, "R2 no error");
    sweep("R2 patterns");

    // R3: CR rewinds only
    send(8'h0D, 1'b1, "R3 no error");
    sweep("R3 text kept");
    send(8'h5A, 1'b1, "R3 no error");
    sweep("R3 write at zero");

    // R5: saturation at the last location
    for (int k = 0; k < 35; k++) send(8'h61 + 8'(k % 26), 1'b1, "R5 no error");
    sweep("R5 saturate");

    // R6: bad stop bit
    send(8'h51, 1'b0, "R6 one error cycle");
    sweep("R6 no store");

    // R7: short glitch
    begin
      int e0;
      e0 = err_hi;
      @(negedge clk);
      rx = 1'b0;
      repeat (BITC / 4) @(negedge clk);
      rx = 1'b1;
      repeat (12 * BITC) @(negedge clk);
      check(8'(err_hi - e0), 8'd0, "R7 no error");
    end
    sweep("R7 no store");

    // R8: read follows address with no clock edge
    @(negedge clk);
    rd_addr = 5'd0;
    #0.1;
    check(rd_data, mdl[0], "R8 addr 0");
    rd_addr = 5'd31;
    #0.1;
    check(rd_data, mdl[31], "R8 addr 31");
    rd_addr = 5'd1;
    #0.1;
    check(rd_data, mdl[1], "R8 addr 1");

    // R4: escape blanks and rewinds
    send(8'h1B, 1'b1, "R4 no error");
    sweep("R4 blank");
    send(8'h4B, 1'b1, "R4 no error");
    sweep("R4 write at zero");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule